// File: doc/BRIEF.md
# Multi-line interrupt aggregator with all-of mode

This block gathers up to twenty single-bit event sources and drives a small set of interrupt lines, four by default. Every line keeps its own latched copy of the events (its raw status) and its own enable vector. Software reads the enabled view of that status, enables or disables events one bit at a time, and clears pending events by writing ones. A per-line mode bit chooses how the line fires. In any-of mode it fires as soon as one enabled event is pending. In all-of mode it fires only once every enabled event is pending, so software can wait on a whole group of producers with a single interrupt.

A few event positions are not latched. They mirror a status level held elsewhere, follow that level, and cannot be set or cleared from here. Each line output gives a one-cycle pulse when its condition becomes true. An end-of-interrupt write naming a line makes the block pulse that line again if its condition still holds, so a level that is still pending is never lost.

Register access uses a simple request port: valid, write, address and data. Every request is accepted in the cycle it is presented, and there is no back-pressure. A read returns its data one cycle later with a response valid strobe.

Top module: `evt_irq_aggr`

## Requirements
- R1: After reset every raw status, enable and mode bit is 0, every interrupt line is low, and every register reads 0.
- R2: A high bit on `evt_pulse` at a clock edge sets that bit in the raw status of every line, whether or not it is enabled. A write of 1 to a raw status register (0x20 + 0x10*k for line k) also sets that bit.
- R3: Writing 1 to a bit of the enabled status register (0x24 + 0x10*k) clears that raw bit of line k, even when the event is disabled. Bits written 0 are unchanged.
- R4: Writing 1s to the enable-set register (0x28 + 0x10*k) enables those events, and writing 1s to the enable-clear register (0x2C + 0x10*k) disables them. Both addresses read the current enable vector.
- R5: In any-of mode a line's condition is that some enabled event is pending. When the condition becomes true after clock edge E, the line is high for exactly the cycle that follows edge E+1. The enabled status register reads raw AND enable.
- R6: Bit k of the mode register at 0x18 selects all-of mode for line k. In that mode the line fires only when every enabled event is pending, and it never fires when the enable vector is empty.
- R7: In all-of mode the enabled status register reads 0 until every enabled event is pending. The raw status register still shows the partial progress.
- R8: The mirror positions (bits 0 and 18 by default) follow `evt_level` one clock later. Raw-set writes, status-clear writes and `evt_pulse` have no effect on them.
- R9: Writing line number k to the end-of-interrupt register at 0x1C (bits 1:0) pulses line k once more if its condition still holds, and does nothing if it does not. The register always reads 0.
- R10: When an event and a software clear hit the same raw bit in the same cycle, the bit ends up set.
- R11: Bits 31:20 of every register read 0 and ignore writes. Unmapped addresses read 0.
- R12: Each read request gives exactly one `rsp_valid` cycle on the next clock, and write requests give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_EVT | Event strobes that set latched raw bits |
| evt_level | input | NUM_EVT | Levels copied into the mirror positions |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | NUM_LINES | One-cycle interrupt pulses, one bit per line |

## Verification
The embedded properties assume the register port carries at most one request per cycle, that reads have no side effects, and that `evt_pulse` bits at mirror positions carry no meaning. They also assume a status-clear and a raw-set write never arrive together, which the single-request port already guarantees. The stimulus drives every input on the falling edge and issues one request at a time. It keeps event strobes one cycle wide. The one exception is the deliberate collision case, where an event strobe and a clear write are placed in the same cycle.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  typedef enum logic [1:0] {
    SEL_RAW   = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_ENSET = 2'd2,
    SEL_ENCLR = 2'd3
  } line_sel_e;

  typedef struct packed {
    logic raw;
    logic stat;
    logic ens;
    logic enc;
  } line_wr_t;

  localparam int unsigned OFS_MODE    = 32'h18;
  localparam int unsigned OFS_EOI     = 32'h1C;
  localparam int unsigned OFS_LINE    = 32'h20;
  localparam int unsigned LINE_STRIDE = 32'h10;
endpackage

// File: rtl/aggr_decode.sv
module aggr_decode #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  output aggr_pkg::line_wr_t [NUM_LINES-1:0]     line_wr,
  output logic                                   mode_we,
  output logic                                   eoi_we,
  output logic                                   rd_line,
  output logic                                   rd_mode,
  output logic [IDX_W-1:0]                       line_idx,
  output aggr_pkg::line_sel_e                    line_sel
);
  import aggr_pkg::*;

  logic [ADDR_W:0] off;
  logic            in_line;
  logic            wr_go;
  logic            rd_go;

  always_comb begin
    off      = {1'b0, req_addr} - (ADDR_W+1)'(OFS_LINE);
    in_line  = !off[ADDR_W] && (off[1:0] == 2'b00) &&
               (32'(off[ADDR_W-1:4]) < NUM_LINES);
    line_idx = off[IDX_W+3:4];
    line_sel = line_sel_e'(off[3:2]);
    wr_go    = req_valid && req_write;
    rd_go    = req_valid && !req_write;
    mode_we  = wr_go && (32'(req_addr) == OFS_MODE);
    eoi_we   = wr_go && (32'(req_addr) == OFS_EOI);
    rd_line  = rd_go && in_line;
    rd_mode  = rd_go && (32'(req_addr) == OFS_MODE);
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_wr
    logic hit;
    assign hit            = wr_go && in_line && (line_idx == IDX_W'(k));
    assign line_wr[k].raw  = hit && (line_sel == SEL_RAW);
    assign line_wr[k].stat = hit && (line_sel == SEL_STAT);
    assign line_wr[k].ens  = hit && (line_sel == SEL_ENSET);
    assign line_wr[k].enc  = hit && (line_sel == SEL_ENCLR);
  end
endmodule

// File: rtl/aggr_line.sv
module aggr_line #(
  parameter int unsigned          NUM_EVT     = 20,
  parameter logic [NUM_EVT-1:0]   MIRROR_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_set,
  input  logic [NUM_EVT-1:0]  mirror_lvl,
  input  logic [NUM_EVT-1:0]  wr_data,
  input  aggr_pkg::line_wr_t  wr,
  input  logic                and_mode,
  input  logic                eoi_hit,
  output logic [NUM_EVT-1:0]  raw_q,
  output logic [NUM_EVT-1:0]  en_q,
  output logic [NUM_EVT-1:0]  stat,
  output logic                irq_q
);
  localparam logic [NUM_EVT-1:0] LATCH_MASK = ~MIRROR_MASK;

  logic [NUM_EVT-1:0] raw_d;
  logic [NUM_EVT-1:0] en_d;
  logic [NUM_EVT-1:0] pend;
  logic               any_hit;
  logic               all_hit;
  logic               cond;
  logic               cond_q;

  // Event strobes are merged last so that a same-cycle clear loses.
  always_comb begin
    raw_d = raw_q;
    if (wr.raw)  raw_d = raw_d | wr_data;
    if (wr.stat) raw_d = raw_d & ~wr_data;
    raw_d = raw_d | evt_set;
    raw_d = (raw_d & LATCH_MASK) | (mirror_lvl & MIRROR_MASK);
  end

  always_comb begin
    en_d = en_q;
    if (wr.ens) en_d = en_d | wr_data;
    if (wr.enc) en_d = en_d & ~wr_data;
  end

  always_comb begin
    pend    = raw_q & en_q;
    any_hit = |pend;
    all_hit = (en_q != '0) && (pend == en_q);
    cond    = and_mode ? all_hit : any_hit;
    stat    = and_mode ? (all_hit ? pend : '0) : pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      en_q   <= '0;
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      en_q   <= en_d;
      cond_q <= cond;
      irq_q  <= (cond && !cond_q) || (eoi_hit && cond);
    end
  end

  // R2 and R10: a latched event bit is set on the edge after its strobe.
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & LATCH_MASK) != '0) |=>
      ((raw_q & $past(evt_set & LATCH_MASK)) == $past(evt_set & LATCH_MASK)));

  a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.stat && ((wr_data & ~evt_set & LATCH_MASK) != '0)) |=>
      ((raw_q & $past(wr_data & ~evt_set & LATCH_MASK)) == '0));

  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr.ens |=> ((en_q & $past(wr_data)) == $past(wr_data)));

  a_r4_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr.enc |=> ((en_q & $past(wr_data)) == '0));

  a_r6_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (and_mode && (en_q == '0)) |=> !irq_q);

  a_r8_mirror_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & MIRROR_MASK) == $past(mirror_lvl & MIRROR_MASK)));
endmodule

// File: rtl/aggr_readmux.sv
module aggr_readmux #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_EVT   = 20,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0][NUM_EVT-1:0] raw,
  input  logic [NUM_LINES-1:0][NUM_EVT-1:0] en,
  input  logic [NUM_LINES-1:0][NUM_EVT-1:0] stat,
  input  logic [NUM_LINES-1:0]              mode,
  input  logic                              rd_line,
  input  logic                              rd_mode,
  input  logic [IDX_W-1:0]                  line_idx,
  input  aggr_pkg::line_sel_e               line_sel,
  output logic [DATA_W-1:0]                 rdata
);
  import aggr_pkg::*;

  always_comb begin
    rdata = '0;
    if (rd_mode) begin
      rdata[NUM_LINES-1:0] = mode;
    end else if (rd_line) begin
      unique case (line_sel)
        SEL_RAW:   rdata[NUM_EVT-1:0] = raw[line_idx];
        SEL_STAT:  rdata[NUM_EVT-1:0] = stat[line_idx];
        SEL_ENSET,
        SEL_ENCLR: rdata[NUM_EVT-1:0] = en[line_idx];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr #(
  parameter int unsigned        NUM_EVT     = 20,
  parameter int unsigned        NUM_LINES   = 4,
  parameter int unsigned        ADDR_W      = 8,
  parameter int unsigned        DATA_W      = 32,
  parameter logic [NUM_EVT-1:0] MIRROR_MASK = 20'h40001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVT-1:0]    evt_pulse,
  input  logic [NUM_EVT-1:0]    evt_level,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [NUM_LINES-1:0]  irq
);
  import aggr_pkg::*;

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  line_wr_t [NUM_LINES-1:0]          line_wr;
  logic                              mode_we;
  logic                              eoi_we;
  logic                              rd_line;
  logic                              rd_mode;
  logic [IDX_W-1:0]                  line_idx;
  line_sel_e                         line_sel;
  logic [NUM_LINES-1:0]              mode_q;
  logic [NUM_LINES-1:0]              eoi_hit;
  logic [NUM_LINES-1:0][NUM_EVT-1:0] raw_v;
  logic [NUM_LINES-1:0][NUM_EVT-1:0] en_v;
  logic [NUM_LINES-1:0][NUM_EVT-1:0] stat_v;
  logic [DATA_W-1:0]                 rdata;

  aggr_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .line_wr(line_wr), .mode_we(mode_we), .eoi_we(eoi_we),
    .rd_line(rd_line), .rd_mode(rd_mode),
    .line_idx(line_idx), .line_sel(line_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= req_wdata[NUM_LINES-1:0];
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign eoi_hit[k] = eoi_we && (req_wdata[IDX_W-1:0] == IDX_W'(k));

    aggr_line #(.NUM_EVT(NUM_EVT), .MIRROR_MASK(MIRROR_MASK)) u_line (
      .clk(clk), .rst_n(rst_n),
      .evt_set(evt_pulse), .mirror_lvl(evt_level),
      .wr_data(req_wdata[NUM_EVT-1:0]), .wr(line_wr[k]),
      .and_mode(mode_q[k]), .eoi_hit(eoi_hit[k]),
      .raw_q(raw_v[k]), .en_q(en_v[k]), .stat(stat_v[k]),
      .irq_q(irq[k])
    );
  end

  aggr_readmux #(.NUM_LINES(NUM_LINES), .NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_rmux (
    .raw(raw_v), .en(en_v), .stat(stat_v), .mode(mode_q),
    .rd_line(rd_line), .rd_mode(rd_mode),
    .line_idx(line_idx), .line_sel(line_sel), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rdata;
    end
  end

  a_r12_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:NUM_EVT] == '0));
endmodule

// File: tb/sim_evt_irq_aggr.sv
module sim_evt_irq_aggr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] evt_pulse = '0;
  logic [19:0] evt_level = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq;

  evt_irq_aggr u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_level(evt_level),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int n_reads = 0;
  int n_rsp = 0;
  int pulses[4] = '{0, 0, 0, 0};
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] a_raw(int k);  return 8'(32'h20 + 16*k); endfunction
  function automatic logic [7:0] a_stat(int k); return 8'(32'h24 + 16*k); endfunction
  function automatic logic [7:0] a_ens(int k);  return 8'(32'h28 + 16*k); endfunction
  function automatic logic [7:0] a_enc(int k);  return 8'(32'h2C + 16*k); endfunction
  localparam logic [7:0] A_MODE = 8'h18;
  localparam logic [7:0] A_EOI  = 8'h1C;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read response.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) if (irq[k]) pulses[k]++;
      if (rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R12: actual unexpected response 0x%08h expected none", rsp_rdata);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag); n_reads++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [19:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(a_raw(0), 0, "R1 raw0");
    rd(a_stat(2), 0, "R1 stat2");
    rd(a_ens(3), 0, "R1 en3");
    rd(A_MODE, 0, "R1 mode");

    // R2 event latches without enable
    pulse(20'h00020);
    rd(a_raw(0), 32'h20, "R2 raw0");
    rd(a_raw(3), 32'h20, "R2 raw3");
    rd(a_stat(0), 0, "R5 stat0 disabled");

    // R3 clear through enabled status while disabled
    wr(a_stat(1), 32'h0);
    rd(a_raw(1), 32'h20, "R3 zero write");
    wr(a_stat(1), 32'h20);
    rd(a_raw(1), 0, "R3 raw1 cleared");
    rd(a_raw(0), 32'h20, "R3 raw0 kept");

    // R4 enables, R5 any-of fires
    wr(a_ens(0), 32'h22);
    rd(a_ens(0), 32'h22, "R4 set view");
    rd(a_enc(0), 32'h22, "R4 clr view");
    rd(a_stat(0), 32'h20, "R5 stat0");
    idle(3);
    check("R5 line0 pulses", pulses[0], 1);
    wr(a_enc(0), 32'h2);
    rd(a_ens(0), 32'h20, "R4 after clear");

    // R9 end of interrupt
    wr(A_EOI, 32'h0);
    idle(3);
    check("R9 eoi repulse", pulses[0], 2);
    rd(A_EOI, 0, "R9 eoi reads 0");
    wr(A_EOI, 32'h2);
    idle(3);
    check("R9 eoi no cond", pulses[2], 0);

    // R5 exact pulse timing
    wr(a_ens(1), 32'h100);
    @(negedge clk); evt_pulse = 20'h00100;
    @(negedge clk); evt_pulse = '0;
    check("R5 timing t1", 32'(irq[1]), 0);
    @(negedge clk);
    check("R5 timing t2", 32'(irq[1]), 1);
    @(negedge clk);
    check("R5 timing t3", 32'(irq[1]), 0);
    idle(2);
    check("R5 line1 pulses", pulses[1], 1);

    // R6 / R7 all-of on line 2
    wr(A_MODE, 32'h4);
    wr(a_stat(2), 32'hFFFFF);
    rd(a_raw(2), 0, "R3 raw2 cleared");
    wr(a_ens(2), 32'hC00);
    pulse(20'h00400);
    rd(a_raw(2), 32'h400, "R7 partial raw");
    rd(a_stat(2), 0, "R7 partial stat");
    idle(2);
    check("R6 partial silent", pulses[2], 0);
    pulse(20'h00800);
    rd(a_stat(2), 32'hC00, "R7 full stat");
    idle(2);
    check("R6 all pending fires", pulses[2], 1);

    // R6 empty mask in all-of mode
    wr(A_MODE, 32'hC);
    rd(A_MODE, 32'hC, "R6 mode readback");
    pulse(20'h00080);
    wr(A_EOI, 32'h3);
    rd(a_stat(3), 0, "R6 empty stat");
    idle(3);
    check("R6 empty mask silent", pulses[3], 0);

    // R2 debug set, R8 mirrors
    wr(a_stat(3), 32'hFFFFF);
    rd(a_raw(3), 0, "R3 raw3 cleared");
    wr(a_raw(3), 32'h10);
    rd(a_raw(3), 32'h10, "R2 debug set");
    wr(a_stat(3), 32'h10);
    evt_level = 20'h40001;
    idle(2);
    rd(a_raw(3), 32'h40001, "R8 mirror up");
    wr(a_stat(3), 32'h40001);
    rd(a_raw(3), 32'h40001, "R8 clear ignored");
    @(negedge clk); evt_level = '0;
    idle(2);
    rd(a_raw(3), 0, "R8 mirror down");
    wr(a_raw(3), 32'h40001);
    rd(a_raw(3), 0, "R8 set ignored");
    pulse(20'h00001);
    rd(a_raw(3), 0, "R8 strobe ignored");

    // R10 event beats same-cycle clear
    @(negedge clk);
    evt_pulse = 20'h01000;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a_stat(3); req_wdata = 32'h1000;
    @(negedge clk);
    evt_pulse = '0; req_valid = 1'b0; req_write = 1'b0;
    rd(a_raw(3), 32'h1000, "R10 event wins");

    // R11 reserved bits and holes
    wr(a_raw(3), 32'hFFF0_0000);
    rd(a_raw(3), 32'h1000, "R11 raw reserved");
    wr(a_ens(0), 32'hFFF0_0000);
    rd(a_ens(0), 32'h20, "R11 enable reserved");
    rd(8'h04, 0, "R11 hole low");
    rd(8'h60, 0, "R11 hole high");

    idle(3);
    check("R12 response count", n_rsp, n_reads);
    check("R12 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule